// File: doc/BRIEF.md
# Composite Video Sync and Gray-Bar Generator

This block produces monochrome composite video timing for a 525-line interlaced raster from a free-running oscillator clock. Each cycle it emits a 2-bit level code that drives a small off-chip resistor ladder. The four codes select the sync tip, the blank level, gray or white. It builds the complete vertical interval in every field: a group of equalizing half-line pulses, a group of serrated broad pulses, a second equalizing group, then blank lines carrying only line sync. The second field starts half a line later than the first, which is what gives the interlace.

Picture lines carry a test image of horizontal bands. The band level follows the two most significant bits of a per-field line counter. The same counter is brought out together with a field flag and a one-clock strobe at every line-sync leading edge, so that neighbouring logic can key switching decisions to the raster. All timing is given as clock counts in parameters. The defaults suit a 27 MHz clock, where one line is 1716 clocks.

Top module: `csg_composite_sync`

## Requirements
- R1: While `rst_i` is high, and on the first output cycle after a clock edge that samples it high, `level_o` is blank (code 01), `field_o` is 0, `line_cnt_o` is 0 and `hsync_stb_o` is 0. After release the generator starts at the first clock of line 0 of the first field.
- R2: The level codes are 00 sync tip, 01 blank, 10 gray and 11 white. A picture line shows blank for FP_CLKS clocks, then sync tip for HS_CLKS clocks, then blank for BP_CLKS clocks, then the bar level until the line ends.
- R3: The bar level depends on the top two bits of `line_cnt_o`: 00 gives blank, 01 gives gray, 10 gives white and 11 gives gray.
- R4: Every line lasts LINE_CLKS clocks and every frame lasts LINES lines. Each output shows the raster position that was current one clock earlier.
- R5: In each field, half-lines 0 to 2*EQ_LINES-1 and the second group of 2*EQ_LINES half-lines that follows the serration group are equalizing half-lines. Each one is at sync tip for EQ_CLKS clocks starting FP_CLKS clocks after the half-line begins, and at blank otherwise.
- R6: The 2*SERR_LINES serration half-lines are at sync tip for LINE_CLKS/2 - SERR_CLKS clocks, starting FP_CLKS clocks into the half-line, and at blank for the rest of the half-line.
- R7: The next 2*BLANK_LINES half-lines are blank except for the line-sync pulse of R2 in the first half of each line.
- R8: The first field covers frame half-lines 0 to LINES-1 and the second field covers half-lines LINES to 2*LINES-1, so the second field starts in the middle of a line. `field_o` is 0 in the first field and 1 in the second.
- R9: `line_cnt_o` is the line number within the field modulo 2^CNT_W. It is 0 at the start of each field and increases by one at every line start.
- R10: `hsync_stb_o` is high for exactly one clock per line, FP_CLKS clocks after the line starts. That clock is the first sync-tip clock of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| level_o | output | 2 | Level code driving the resistor ladder |
| field_o | output | 1 | 0 in the first field, 1 in the second |
| line_cnt_o | output | CNT_W | Line number within the field |
| hsync_stb_o | output | 1 | One-clock strobe at each line-sync leading edge |

## Verification
The hardest case to reach is the handover into the second field. It happens half a line into a frame line, where the field flag, the line-count restart and the start of the equalizing train must all meet at one clock, and a full-size raster needs more than 400,000 clocks to get there. The bench therefore shrinks the line to 40 clocks and the frame to 71 lines. It then checks every output on every clock over two whole frames against a position model, so both field handovers, the counter wrap and all four bar codes are visited. A reset applied in the middle of the run shows that the raster restarts from its origin.

// File: rtl/csg_pkg.sv
package csg_pkg;

  typedef enum logic [1:0] {
    LVL_TIP   = 2'b00,
    LVL_BLANK = 2'b01,
    LVL_GRAY  = 2'b10,
    LVL_WHITE = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    RG_EQ,
    RG_SERR,
    RG_VBLANK,
    RG_PICT
  } region_e;

endpackage

// File: rtl/csg_raster_counter.sv
module csg_raster_counter #(
  parameter int LINE_CLKS = 1716,
  parameter int LINES     = 525,
  parameter int XW        = 11,
  parameter int LW        = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic [XW-1:0] x_o,
  output logic [LW-1:0] ln_o
);

  logic [XW-1:0] x_q;
  logic [LW-1:0] ln_q;
  logic          line_end;

  assign line_end = (x_q == XW'(LINE_CLKS - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      x_q  <= '0;
      ln_q <= '0;
    end else if (line_end) begin
      x_q  <= '0;
      ln_q <= (ln_q == LW'(LINES - 1)) ? '0 : ln_q + 1'b1;
    end else begin
      x_q <= x_q + 1'b1;
    end
  end

  assign x_o  = x_q;
  assign ln_o = ln_q;

  // R4: a line ends and the next starts at position zero of the line
  a_r4_line_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    line_end |=> (x_q == '0));

endmodule

// File: rtl/csg_field_decoder.sv
module csg_field_decoder
  import csg_pkg::*;
#(
  parameter int LINE_CLKS   = 1716,
  parameter int LINES       = 525,
  parameter int EQ_LINES    = 3,
  parameter int SERR_LINES  = 3,
  parameter int BLANK_LINES = 11,
  parameter int CNT_W       = 8,
  parameter int XW          = 11,
  parameter int LW          = 10,
  parameter int HLW         = 11
) (
  input  logic [XW-1:0]    x_i,
  input  logic [LW-1:0]    ln_i,
  output logic             field_o,
  output region_e          region_o,
  output logic [XW-1:0]    hpx_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int HALF      = LINE_CLKS / 2;
  localparam int HL_EQ1    = 2 * EQ_LINES;
  localparam int HL_SERR   = HL_EQ1 + 2 * SERR_LINES;
  localparam int HL_EQ2    = HL_SERR + 2 * EQ_LINES;
  localparam int HL_VBLANK = HL_EQ2 + 2 * BLANK_LINES;
  localparam int F2_LINE   = (LINES - 1) / 2;

  logic           upper_half;
  logic [HLW-1:0] hl;
  logic [HLW-1:0] fh;

  always_comb begin
    upper_half = (x_i >= XW'(HALF));
    hl         = HLW'({ln_i, 1'b0}) + HLW'(upper_half);
    field_o    = (hl >= HLW'(LINES));
    fh         = field_o ? (hl - HLW'(LINES)) : hl;
    hpx_o      = upper_half ? (x_i - XW'(HALF)) : x_i;
    cnt_o      = field_o ? (CNT_W'(ln_i) - CNT_W'(F2_LINE)) : CNT_W'(ln_i);

    if (fh < HLW'(HL_EQ1))         region_o = RG_EQ;
    else if (fh < HLW'(HL_SERR))   region_o = RG_SERR;
    else if (fh < HLW'(HL_EQ2))    region_o = RG_EQ;
    else if (fh < HLW'(HL_VBLANK)) region_o = RG_VBLANK;
    else                           region_o = RG_PICT;
  end

endmodule

// File: rtl/csg_level_painter.sv
module csg_level_painter
  import csg_pkg::*;
#(
  parameter int LINE_CLKS = 1716,
  parameter int FP_CLKS   = 32,
  parameter int HS_CLKS   = 127,
  parameter int BP_CLKS   = 85,
  parameter int EQ_CLKS   = 62,
  parameter int SERR_CLKS = 127,
  parameter int XW        = 11
) (
  input  logic [XW-1:0] x_i,
  input  logic [XW-1:0] hpx_i,
  input  region_e       region_i,
  input  logic [1:0]    bar_i,
  output lvl_e          level_o,
  output logic          stb_o
);

  localparam int HALF      = LINE_CLKS / 2;
  localparam int EQ_END    = FP_CLKS + EQ_CLKS;
  localparam int SERR_END  = FP_CLKS + HALF - SERR_CLKS;
  localparam int SYNC_END  = FP_CLKS + HS_CLKS;
  localparam int PICT_BEG  = SYNC_END + BP_CLKS;

  lvl_e bar_lvl;
  logic in_eq, in_serr, in_sync;

  always_comb begin
    unique case (bar_i)
      2'b00:   bar_lvl = LVL_BLANK;
      2'b01:   bar_lvl = LVL_GRAY;
      2'b10:   bar_lvl = LVL_WHITE;
      default: bar_lvl = LVL_GRAY;
    endcase
  end

  assign in_eq   = (hpx_i >= XW'(FP_CLKS)) && (hpx_i < XW'(EQ_END));
  assign in_serr = (hpx_i >= XW'(FP_CLKS)) && (hpx_i < XW'(SERR_END));
  assign in_sync = (x_i >= XW'(FP_CLKS)) && (x_i < XW'(SYNC_END));
  assign stb_o   = (x_i == XW'(FP_CLKS));

  always_comb begin
    level_o = LVL_BLANK;
    unique case (region_i)
      RG_EQ:     if (in_eq)   level_o = LVL_TIP;
      RG_SERR:   if (in_serr) level_o = LVL_TIP;
      RG_VBLANK: if (in_sync) level_o = LVL_TIP;
      RG_PICT: begin
        if (in_sync)                         level_o = LVL_TIP;
        else if (x_i >= XW'(PICT_BEG))       level_o = bar_lvl;
      end
    endcase
  end

endmodule

// File: rtl/csg_composite_sync.sv
module csg_composite_sync
  import csg_pkg::*;
#(
  parameter int LINE_CLKS   = 1716,
  parameter int LINES       = 525,
  parameter int FP_CLKS     = 32,
  parameter int HS_CLKS     = 127,
  parameter int BP_CLKS     = 85,
  parameter int EQ_CLKS     = 62,
  parameter int SERR_CLKS   = 127,
  parameter int EQ_LINES    = 3,
  parameter int SERR_LINES  = 3,
  parameter int BLANK_LINES = 11,
  parameter int CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [1:0]       level_o,
  output logic             field_o,
  output logic [CNT_W-1:0] line_cnt_o,
  output logic             hsync_stb_o
);

  localparam int XW  = $clog2(LINE_CLKS);
  localparam int LW  = $clog2(LINES);
  localparam int HLW = $clog2(2 * LINES);

  logic [XW-1:0]    x, hpx;
  logic [LW-1:0]    ln;
  logic             field_d, stb_d;
  region_e          region;
  logic [CNT_W-1:0] cnt_d;
  lvl_e             level_d;

  csg_raster_counter #(
    .LINE_CLKS(LINE_CLKS), .LINES(LINES), .XW(XW), .LW(LW)
  ) u_raster (
    .clk_i(clk_i), .rst_i(rst_i), .x_o(x), .ln_o(ln)
  );

  csg_field_decoder #(
    .LINE_CLKS(LINE_CLKS), .LINES(LINES), .EQ_LINES(EQ_LINES),
    .SERR_LINES(SERR_LINES), .BLANK_LINES(BLANK_LINES), .CNT_W(CNT_W),
    .XW(XW), .LW(LW), .HLW(HLW)
  ) u_decode (
    .x_i(x), .ln_i(ln), .field_o(field_d), .region_o(region),
    .hpx_o(hpx), .cnt_o(cnt_d)
  );

  csg_level_painter #(
    .LINE_CLKS(LINE_CLKS), .FP_CLKS(FP_CLKS), .HS_CLKS(HS_CLKS),
    .BP_CLKS(BP_CLKS), .EQ_CLKS(EQ_CLKS), .SERR_CLKS(SERR_CLKS), .XW(XW)
  ) u_paint (
    .x_i(x), .hpx_i(hpx), .region_i(region), .bar_i(cnt_d[CNT_W-1 -: 2]),
    .level_o(level_d), .stb_o(stb_d)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      level_o     <= LVL_BLANK;
      field_o     <= 1'b0;
      line_cnt_o  <= '0;
      hsync_stb_o <= 1'b0;
    end else begin
      level_o     <= level_d;
      field_o     <= field_d;
      line_cnt_o  <= cnt_d;
      hsync_stb_o <= stb_d;
    end
  end

  // Clocks since the previous line strobe, for the period check
  int   gap_q;
  logic seen_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (hsync_stb_o) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk_i)
    $past(rst_i) |-> (level_o == LVL_BLANK && !field_o &&
                      line_cnt_o == '0 && !hsync_stb_o));

  a_r10_strobe_on_tip: assert property (@(posedge clk_i) disable iff (rst_i)
    hsync_stb_o |-> (level_o == LVL_TIP));

  a_r10_strobe_period: assert property (@(posedge clk_i) disable iff (rst_i)
    (hsync_stb_o && seen_q) |-> (gap_q == LINE_CLKS - 1));

  a_r8_field_restarts_count: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(field_o) |-> (line_cnt_o == '0));

  a_r9_count_steps_by_one: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(line_cnt_o) && $stable(field_o)) |->
      (line_cnt_o == CNT_W'($past(line_cnt_o) + 1'b1)));

endmodule

// File: tb/tb_csg_composite_sync.sv
module tb_csg_composite_sync;

  localparam int L   = 40;
  localparam int N   = 71;
  localparam int H   = L / 2;
  localparam int FP  = 2;
  localparam int HS  = 4;
  localparam int BP  = 3;
  localparam int EQ  = 2;
  localparam int SE  = 4;
  localparam int CW  = 4;
  localparam int FRAME = L * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    level;
  logic          field;
  logic [CW-1:0] cnt;
  logic          stb;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  csg_composite_sync #(
    .LINE_CLKS(L), .LINES(N), .FP_CLKS(FP), .HS_CLKS(HS), .BP_CLKS(BP),
    .EQ_CLKS(EQ), .SERR_CLKS(SE), .EQ_LINES(3), .SERR_LINES(3),
    .BLANK_LINES(11), .CNT_W(CW)
  ) dut (
    .clk_i(clk), .rst_i(rst), .level_o(level), .field_o(field),
    .line_cnt_o(cnt), .hsync_stb_o(stb)
  );

  task automatic check(input string req, input int act, input int exp, input int pos);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", req, pos, act, exp);
    end
  endtask

  // Expected outputs for raster position p (clocks since release)
  task automatic model(input int p, output int lvl, output int fld,
                       output int c, output int s, output string tag);
    int pp, x, ln, hl, fh, hpx, fl, bar;
    pp  = p % FRAME;
    x   = pp % L;
    ln  = pp / L;
    hl  = 2 * ln + ((x >= H) ? 1 : 0);
    fld = (hl >= N) ? 1 : 0;
    fh  = fld ? hl - N : hl;
    hpx = (x >= H) ? x - H : x;
    fl  = fld ? ln - (N - 1) / 2 : ln;
    c   = fl % (1 << CW);
    s   = (x == FP) ? 1 : 0;
    bar = (c >> (CW - 2)) & 3;
    if (fh < 6 || (fh >= 12 && fh < 18)) begin
      tag = "R5";
      lvl = (hpx >= FP && hpx < FP + EQ) ? 0 : 1;
    end else if (fh < 12) begin
      tag = "R6";
      lvl = (hpx >= FP && hpx < FP + H - SE) ? 0 : 1;
    end else if (fh < 40) begin
      tag = "R7";
      lvl = (x >= FP && x < FP + HS) ? 0 : 1;
    end else if (x < FP + HS + BP) begin
      tag = "R2";
      lvl = (x >= FP && x < FP + HS) ? 0 : 1;
    end else begin
      tag = "R3";
      lvl = (bar == 0) ? 1 : (bar == 2) ? 3 : 2;
    end
  endtask

  task automatic check_pos(input int p);
    int el, ef, ec, es;
    string tag;
    model(p, el, ef, ec, es, tag);
    check(tag, int'(level), el, p);
    check("R8", int'(field), ef, p);
    check("R9", int'(cnt), ec, p);
    check("R10", int'(stb), es, p);
  endtask

  task automatic check_reset_state();
    check("R1 level", int'(level), 1, -1);
    check("R1 field", int'(field), 0, -1);
    check("R1 count", int'(cnt), 0, -1);
    check("R1 strobe", int'(stb), 0, -1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int strobes, bars_seen;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();                       // R1 at power-up
    rst = 1'b0;
    strobes = 0;
    bars_seen = 0;
    for (int p = 0; p < 2 * FRAME + 60; p++) begin
      @(negedge clk);
      check_pos(p);
      if (p < FRAME && stb) strobes++;
      if (level == 2'b10) bars_seen |= 1;
      if (level == 2'b11) bars_seen |= 2;
    end
    check("R4 strobes per frame", strobes, N, FRAME);
    check("R3 gray and white bars present", bars_seen, 3, 0);
    // Reset in the middle of a field restarts the raster at its origin
    repeat (777) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();                       // R1 mid-run
    rst = 1'b0;
    for (int p = 0; p < 3 * L; p++) begin
      @(negedge clk);
      check_pos(p);                            // R4 restart from line 0
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule